// File: doc/BRIEF.md
# Lazy Chunk Writeback Tracker

This block keeps the dirty state of a directly addressed local store at 64-byte chunk granularity and holds every writeback back until the chunk is evicted. A store that writes a clean chunk marks it dirty and records which mapping entry the chunk came from. It also raises that entry's count of outstanding dirty chunks. Later stores to a chunk that is already dirty leave the record and the count alone.

An eviction request names a chunk. If that chunk is dirty, the block presents the chunk and its recorded mapping entry on a combinational lookup port. The mapping unit answers with the chunk's global address. The block then raises a writeback request carrying that address. When the request is accepted, the dirty bit clears and the entry's count goes down. Evicting a clean chunk produces nothing. A per-entry zero flag tells the mapping unit when an entry no longer owns any dirty chunk and may be released. Nothing is ever written back at synchronisation points. Writebacks happen only on eviction.

Top module: `chunk_wb_tracker`

## Requirements
- R1: After reset every chunk is clean. Every bit of `map_clean` is 1, `wb_valid` is 0 and `ev_ready` is 1.
- R2: A store to a clean chunk makes it dirty, records `st_map` as its owner and raises that entry's count, so `map_clean[st_map]` reads 0 from the next cycle.
- R3: A store to a chunk that is already dirty changes neither the recorded owner nor any count.
- R4: While an eviction is presented, `lk_chunk` equals `ev_chunk` and `lk_map` equals the chunk's recorded owner. An accepted eviction of a dirty chunk raises `wb_valid` in the next cycle. The request carries `wb_addr` equal to the `lk_addr` returned during the eviction cycle, together with the chunk number and the owner.
- R5: An accepted eviction of a clean chunk raises no writeback and changes no count.
- R6: While `wb_valid` is 1 and `wb_ready` is 0, the request and its fields stay unchanged and `ev_ready` is 0.
- R7: When `wb_valid` and `wb_ready` are both 1 at a clock edge, the chunk becomes clean and its owner's count falls by one. Evicting the chunk again raises no writeback.
- R8: `map_clean[m]` is 1 exactly when entry m owns no dirty chunk.
- R9: `wb_valid` rises only in the cycle after an accepted eviction of a dirty chunk.
- R10: A store that newly dirties a chunk of entry m in the same cycle as an accepted writeback of entry m leaves entry m's count unchanged.
- Usage rule: a store must not target the chunk of a pending writeback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | A store writes chunk `st_chunk` this cycle |
| st_chunk | input | CHUNK_W | Chunk written by the store |
| st_map | input | MAP_W | Mapping entry the store belongs to |
| ev_valid | input | 1 | Eviction request |
| ev_chunk | input | CHUNK_W | Chunk to evict |
| ev_ready | output | 1 | Eviction accepted when high together with `ev_valid` |
| lk_chunk | output | CHUNK_W | Chunk presented to the mapping unit |
| lk_map | output | MAP_W | Recorded owner presented to the mapping unit |
| lk_addr | input | ADDR_W | Global address returned by the mapping unit (same cycle) |
| wb_valid | output | 1 | Writeback request pending |
| wb_ready | input | 1 | Writeback accepted |
| wb_addr | output | ADDR_W | Global address of the writeback |
| wb_chunk | output | CHUNK_W | Chunk being written back |
| wb_map | output | MAP_W | Owner of the chunk being written back |
| map_clean | output | NUM_MAPS | Per-entry flag: entry owns no dirty chunk |

## Verification
The bench builds the block with 8 chunks, 4 mapping entries and a 32-bit address. With only 8 chunks, a single entry can own nearly every chunk, and a fill-then-drain pass runs its counter from zero up to seven and back. With 4 entries, each owner field takes distinct values. The narrow chunk field also makes the encoded address per entry and chunk easy to tell apart in the scoreboard. Stalling the writeback side brings a held request, a blocked eviction and a same-cycle store-and-retire on one entry within a few cycles.

// File: rtl/chunk_wb_tracker.sv
module chunk_wb_tracker #(
  parameter int NUM_CHUNKS = 16,
  parameter int NUM_MAPS   = 4,
  parameter int ADDR_W     = 48,
  localparam int CHUNK_W = $clog2(NUM_CHUNKS),
  localparam int MAP_W   = $clog2(NUM_MAPS),
  localparam int CNT_W   = $clog2(NUM_CHUNKS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_valid,
  input  logic [CHUNK_W-1:0] st_chunk,
  input  logic [MAP_W-1:0]   st_map,
  input  logic               ev_valid,
  input  logic [CHUNK_W-1:0] ev_chunk,
  output logic               ev_ready,
  output logic [CHUNK_W-1:0] lk_chunk,
  output logic [MAP_W-1:0]   lk_map,
  input  logic [ADDR_W-1:0]  lk_addr,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [ADDR_W-1:0]  wb_addr,
  output logic [CHUNK_W-1:0] wb_chunk,
  output logic [MAP_W-1:0]   wb_map,
  output logic [NUM_MAPS-1:0] map_clean
);

  logic [NUM_CHUNKS-1:0] dirty;
  logic [MAP_W-1:0]      owner [NUM_CHUNKS];

  assign ev_ready = !wb_valid;
  assign lk_chunk = ev_chunk;
  assign lk_map   = owner[ev_chunk];

  wire ev_fire = ev_valid && ev_ready;
  wire wb_fire = wb_valid && wb_ready;
  wire st_new  = st_valid && !dirty[st_chunk];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirty <= '0;
      for (int i = 0; i < NUM_CHUNKS; i++) owner[i] <= '0;
    end else begin
      if (wb_fire) dirty[wb_chunk] <= 1'b0;
      if (st_new) begin
        dirty[st_chunk] <= 1'b1;
        owner[st_chunk] <= st_map;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_chunk <= '0;
      wb_map   <= '0;
    end else begin
      if (wb_fire) wb_valid <= 1'b0;
      if (ev_fire && dirty[ev_chunk]) begin
        wb_valid <= 1'b1;
        wb_addr  <= lk_addr;
        wb_chunk <= ev_chunk;
        wb_map   <= owner[ev_chunk];
      end
    end
  end

  for (genvar m = 0; m < NUM_MAPS; m++) begin : g_map
    logic [CNT_W-1:0] cnt;
    wire inc = st_new && (st_map == MAP_W'(m));
    wire dec = wb_fire && (wb_map == MAP_W'(m));
    always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (inc && !dec) cnt <= cnt + 1'b1;
      else if (dec && !inc) cnt <= cnt - 1'b1;
    end
    assign map_clean[m] = (cnt == '0);
  end

endmodule

module chunk_wb_tracker_chk #(
  parameter int NUM_CHUNKS = 16,
  parameter int ADDR_W     = 48,
  parameter int CHUNK_W    = 4,
  parameter int MAP_W      = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  st_valid,
  input logic [CHUNK_W-1:0]    st_chunk,
  input logic                  ev_valid,
  input logic [CHUNK_W-1:0]    ev_chunk,
  input logic                  ev_ready,
  input logic                  wb_valid,
  input logic                  wb_ready,
  input logic [ADDR_W-1:0]     wb_addr,
  input logic [CHUNK_W-1:0]    wb_chunk,
  input logic [MAP_W-1:0]      wb_map,
  input logic [NUM_CHUNKS-1:0] dirty
);

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_chunk) && $stable(wb_map)); // R6

  AST_WB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(ev_valid && ev_ready && dirty[ev_chunk])); // R9

  AST_STORE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> dirty[$past(st_chunk)]); // R2

  AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready && !(st_valid && st_chunk == wb_chunk) |=> !dirty[$past(wb_chunk)]); // R7

  AST_CLEAN_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && !dirty[ev_chunk] |=> !wb_valid); // R5

endmodule

bind chunk_wb_tracker chunk_wb_tracker_chk #(
  .NUM_CHUNKS(NUM_CHUNKS), .ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W), .MAP_W(MAP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_chunk(st_chunk),
  .ev_valid(ev_valid), .ev_chunk(ev_chunk), .ev_ready(ev_ready),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
  .wb_chunk(wb_chunk), .wb_map(wb_map), .dirty(dirty)
);

// File: tb/chunk_wb_tracker_tb_top.sv
module chunk_wb_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int NM = 4;
  localparam int AW = 32;
  localparam int CW = 3;
  localparam int MW = 2;

  logic clk = 0, rst_n = 0;
  logic st_valid = 0, ev_valid = 0, wb_ready = 1;
  logic [CW-1:0] st_chunk = 0, ev_chunk = 0;
  logic [MW-1:0] st_map = 0;
  logic ev_ready, wb_valid;
  logic [CW-1:0] lk_chunk, wb_chunk;
  logic [MW-1:0] lk_map, wb_map;
  logic [AW-1:0] lk_addr, wb_addr;
  logic [NM-1:0] map_clean;

  int checks = 0, errors = 0;
  bit mdirty [NC];
  int mmap [NC];
  int mcnt [NM];
  logic [AW+MW+CW-1:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] gaddr(int m, int c);
    return 32'h4000_0000 + (m << 16) + (c << 6);
  endfunction
  assign lk_addr = gaddr(int'(lk_map), int'(lk_chunk));

  chunk_wb_tracker #(.NUM_CHUNKS(NC), .NUM_MAPS(NM), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_chunk(st_chunk), .st_map(st_map),
    .ev_valid(ev_valid), .ev_chunk(ev_chunk), .ev_ready(ev_ready),
    .lk_chunk(lk_chunk), .lk_map(lk_map), .lk_addr(lk_addr),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .wb_chunk(wb_chunk), .wb_map(wb_map), .map_clean(map_clean));

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check_flags(string req);
    for (int m = 0; m < NM; m++)
      chk(map_clean[m] == (mcnt[m] == 0), req, "map_clean", map_clean[m], mcnt[m] == 0);
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && wb_valid && wb_ready) begin
      if (expq.size() == 0) chk(0, "R9", "unexpected writeback", wb_addr, 0);
      else begin
        logic [AW+MW+CW-1:0] e;
        e = expq.pop_front();
        chk({wb_addr, wb_map, wb_chunk} == e, "R4", "writeback item", {wb_addr, wb_map, wb_chunk}, e);
      end
    end
  end

  task automatic store(int c, int m, string req);
    @(negedge clk);
    st_valid = 1; st_chunk = CW'(c); st_map = MW'(m);
    if (!mdirty[c]) begin mdirty[c] = 1; mmap[c] = m; mcnt[m]++; end
    @(negedge clk);
    st_valid = 0;
    check_flags(req);
  endtask

  task automatic evict(int c, string req);
    bit was_dirty;
    @(negedge clk);
    ev_valid = 1; ev_chunk = CW'(c);
    was_dirty = mdirty[c];
    #1;
    chk(lk_chunk == CW'(c), "R4", "lk_chunk", lk_chunk, c);
    if (was_dirty) begin
      chk(lk_map == MW'(mmap[c]), "R4", "lk_map", lk_map, mmap[c]);
      expq.push_back({gaddr(mmap[c], c), MW'(mmap[c]), CW'(c)});
    end
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 0;
    if (was_dirty) begin
      chk(wb_valid == 1, req, "wb_valid after dirty evict", wb_valid, 1);
      while (wb_valid) @(negedge clk);
      mdirty[c] = 0; mcnt[mmap[c]]--;
    end else begin
      chk(wb_valid == 0, "R5", "wb_valid after clean evict", wb_valid, 0);
    end
    check_flags(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "WATCHDOG", "run timed out", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(wb_valid == 0, "R1", "wb_valid", wb_valid, 0);
    chk(ev_ready == 1, "R1", "ev_ready", ev_ready, 1);
    chk(map_clean == '1, "R1", "map_clean", map_clean, 4'hf);

    store(0, 1, "R2");
    store(5, 2, "R2");
    evict(1, "R5");
    store(0, 3, "R3");
    chk(map_clean[3] == 1, "R3", "no count for re-store", map_clean[3], 1);
    evict(0, "R7");
    evict(0, "R7");
    chk(expq.size() == 0, "R9", "queue drained", expq.size(), 0);

    for (int c = 0; c < NC; c++) store(c, 3, "R8");
    for (int c = 0; c < NC; c++) if (c != 5) evict(c, "R8");
    chk(map_clean[3] == 1, "R8", "map3 drained", map_clean[3], 1);

    store(2, 1, "R2");
    @(negedge clk);
    wb_ready = 0; ev_valid = 1; ev_chunk = 2;
    expq.push_back({gaddr(1, 2), MW'(1), CW'(2)});
    @(negedge clk);
    ev_valid = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(wb_valid == 1, "R6", "held wb_valid", wb_valid, 1);
      chk(ev_ready == 0, "R6", "ev_ready blocked", ev_ready, 0);
      chk(wb_addr == gaddr(1, 2), "R6", "held wb_addr", wb_addr, gaddr(1, 2));
    end
    wb_ready = 1; st_valid = 1; st_chunk = 3; st_map = 1;
    mdirty[2] = 0; mdirty[3] = 1; mmap[3] = 1;
    @(negedge clk);
    st_valid = 0;
    chk(wb_valid == 0, "R7", "request retired", wb_valid, 0);
    chk(map_clean[1] == 0, "R10", "net count on entry 1", map_clean[1], 0);
    evict(2, "R7");
    evict(3, "R10");
    chk(map_clean[1] == 1, "R10", "entry 1 clean", map_clean[1], 1);
    evict(5, "R8");
    chk(map_clean == '1, "R8", "all clean", map_clean, 4'hf);
    chk(expq.size() == 0, "R9", "queue drained", expq.size(), 0);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule